// File: doc/BRIEF.md
# Set-Associative Tag Directory with Line Permissions

This block holds the tag and state side of a set-associative cache. The line data and the coherence controller live elsewhere. For every way of every set it records a valid flag, the line address tag, a permission state and a reservation context number. A controller issues one command per cycle on a single request port: a line address, an opcode and an argument. One cycle later it gets back a registered result flag, a way number, an error flag and, for a victim probe, the line address that must be evicted.

Permissions gate hits. A writable line satisfies any request type. A read-only line satisfies only loads and instruction fetches. Lines in the other states never hit. Each line also carries a reservation context that is wiped whenever the line is reallocated, removed or dropped to an invalidating state. Victims are chosen by a true least-recently-used order kept per set. An illegal command is refused: the error flag is raised and no stored state changes.

Top module: `tagdir_top`

## Requirements
- R1: The set count is CACHE_BYTES / ASSOC / LINE_BYTES and must be a power of two greater than one. The set index is the log2(set count)-bit field of the request address that starts at bit IDX_LSB. The tag is every address bit above the line offset, so the low log2(LINE_BYTES) bits are ignored.
- R2: A request with req_valid high is answered with rsp_valid high on the next cycle. rsp_valid is low in the cycle after an idle cycle. Opcodes are: 0 access, 1 availability, 2 allocate, 3 deallocate, 4 probe, 5 permission change, 6 lock set, 7 lock clear, 8 lock test.
- R3: After reset every way is empty, every lock holds all ones, and in each set the highest-numbered way is the oldest.
- R4: Permission codes are 0 not-present, 1 invalid, 2 read-only, 3 read-write, 4 stale. A line is present when its way is valid, its tag matches and its permission is not 0. An access (req_arg = request type: 0 load, 1 fetch, 2 store) hits on a present read-write line for any type, and on a present read-only line only for load or fetch. rsp_way gives the matching way whenever the line is present and is 0 otherwise.
- R5: An access that finds a present line makes that way the most recently used, even if the permission check fails.
- R6: Availability returns 1 when the line is present, or when some way of the set is empty or not-present.
- R7: Allocate fills the lowest-numbered empty or not-present way. That way becomes permission invalid, its lock becomes all ones and it becomes most recently used. rsp_way gives the way.
- R8: Deallocate empties the way holding the present line and clears its lock. rsp_way gives the way.
- R9: A probe returns in rsp_addr the line address (offset bits zero) held by the least recently used way of a full set, and returns that way in rsp_way.
- R10: A permission change writes req_arg to a present line. A new state of invalid, not-present or stale clears the lock. A change to read-only or read-write keeps the lock.
- R11: Lock set stores req_arg as the line's context, and lock clear sets it to all ones. Lock test returns 1 only when the stored context equals req_arg.
- R12: The following are illegal: allocate on a present line or a full set, deallocate, permission change or any lock command on an absent line, a probe while availability holds, a permission code above 4, and an unknown opcode. Each raises rsp_err for one response with rsp_hit low and leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command present this cycle |
| req_op | input | 4 | Opcode |
| req_addr | input | ADDR_W | Line address (offset bits ignored) |
| req_arg | input | CTX_W | Request type, new permission or context number |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Command result (hit, available, success, lock match) |
| rsp_err | output | 1 | Command refused as illegal |
| rsp_way | output | log2(ASSOC) | Way matched, filled, emptied or chosen |
| rsp_addr | output | ADDR_W | Victim line address from a probe, else zero |

## Verification
Directed sequences fill one set way by way. They then cross every permission state with each request type, so a read-only line under a store can be told apart from one under a load. A failing access is followed by a probe, which shows whether the recency update happened without the hit. Lock contexts are followed through permission changes to preserving and to invalidating states, and through reallocation. Constrained random commands then run over a small tag pool. The pool forces full sets, repeated allocations and absent-line lock commands, and every response is compared with a timestamp-based model of the directory.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
   localparam logic [2:0] PERM_NP    = 3'd0;
   localparam logic [2:0] PERM_INV   = 3'd1;
   localparam logic [2:0] PERM_RO    = 3'd2;
   localparam logic [2:0] PERM_RW    = 3'd3;
   localparam logic [2:0] PERM_STALE = 3'd4;

   typedef enum logic [3:0] {
      OP_ACCESS    = 4'd0,
      OP_AVAIL     = 4'd1,
      OP_ALLOC     = 4'd2,
      OP_DEALLOC   = 4'd3,
      OP_PROBE     = 4'd4,
      OP_PERM      = 4'd5,
      OP_LOCK_SET  = 4'd6,
      OP_LOCK_CLR  = 4'd7,
      OP_LOCK_TEST = 4'd8
   } op_e;

   localparam int REQ_LOAD   = 0;
   localparam int REQ_IFETCH = 1;
endpackage

// File: rtl/tagdir_match.sv
module tagdir_match
   import tagdir_pkg::*;
#(
   parameter int WAYS  = 4,
   parameter int TAG_W = 10,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]            row_valid,
   input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
   input  logic [WAYS-1:0][2:0]       row_perm,
   input  logic [TAG_W-1:0]           key,
   output logic [WAYS-1:0]            match_vec,
   output logic                       present,
   output logic [WAY_W-1:0]           match_way,
   output logic                       any_free,
   output logic [WAY_W-1:0]           free_way
);
   logic [WAYS-1:0] free_vec;

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      assign match_vec[g] = row_valid[g] && (row_tag[g] == key) && (row_perm[g] != PERM_NP);
      assign free_vec[g]  = !row_valid[g] || (row_perm[g] == PERM_NP);
   end

   assign present  = |match_vec;
   assign any_free = |free_vec;

   always_comb begin
      match_way = '0;
      for (int i = 0; i < WAYS; i++)
         if (match_vec[i]) match_way = WAY_W'(i);
   end

   // lowest-numbered free way wins
   always_comb begin
      free_way = '0;
      for (int i = WAYS - 1; i >= 0; i--)
         if (free_vec[i]) free_way = WAY_W'(i);
   end
endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
   parameter int SETS = 4,
   parameter int WAYS = 4,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [SET_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way,
   input  logic [SET_W-1:0] query_set,
   output logic [WAY_W-1:0] victim_way
);
   localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

   logic [WAY_W-1:0] age [SETS][WAYS];
   logic [WAYS-1:0]  oldest_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age[s][w] <= WAY_W'(w);
      end else if (touch_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
               age[touch_set][w] <= '0;
            else if (age[touch_set][w] < age[touch_set][touch_way])
               age[touch_set][w] <= age[touch_set][w] + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < WAYS; g++) begin : g_old
      assign oldest_vec[g] = (age[query_set][g] == OLDEST);
   end

   always_comb begin
      victim_way = '0;
      for (int i = 0; i < WAYS; i++)
         if (oldest_vec[i]) victim_way = WAY_W'(i);
   end

   // R9
   one_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(oldest_vec));
endmodule

// File: rtl/tagdir_top.sv
module tagdir_top
   import tagdir_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int CACHE_BYTES = 1024,
   parameter int ASSOC       = 4,
   parameter int LINE_BYTES  = 64,
   parameter int IDX_LSB     = $clog2(LINE_BYTES),
   parameter int CTX_W       = 4,
   localparam int WAY_W = $clog2(ASSOC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [3:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CTX_W-1:0]  req_arg,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_err,
   output logic [WAY_W-1:0]  rsp_way,
   output logic [ADDR_W-1:0] rsp_addr
);
   localparam int LINE_BITS = $clog2(LINE_BYTES);
   localparam int SETS      = CACHE_BYTES / ASSOC / LINE_BYTES;
   localparam int SET_W     = $clog2(SETS);
   localparam int TAG_W     = ADDR_W - LINE_BITS;
   localparam logic [CTX_W-1:0] CTX_NONE = '1;

   // R1 elaboration checks
   if (SETS < 2 || (1 << SET_W) != SETS) begin : g_bad_sets
      $error("tagdir_top: set count must be a power of two above one");
   end
   if (ASSOC < 2) begin : g_bad_assoc
      $error("tagdir_top: ASSOC must be at least two");
   end
   if (IDX_LSB < LINE_BITS || IDX_LSB + SET_W > ADDR_W) begin : g_bad_idx
      $error("tagdir_top: index field out of range");
   end
   if (CTX_W < 3) begin : g_bad_ctx
      $error("tagdir_top: CTX_W must hold a permission code");
   end

   logic             way_v    [SETS][ASSOC];
   logic [TAG_W-1:0] way_tag  [SETS][ASSOC];
   logic [2:0]       way_perm [SETS][ASSOC];
   logic [CTX_W-1:0] way_lock [SETS][ASSOC];

   logic [SET_W-1:0] cur_set;
   logic [TAG_W-1:0] cur_tag;
   logic             unused_low;

   assign cur_set    = req_addr[IDX_LSB +: SET_W];
   assign cur_tag    = req_addr[ADDR_W-1:LINE_BITS];
   assign unused_low = ^{1'b0, req_addr[LINE_BITS-1:0]};

   logic [ASSOC-1:0]            row_valid;
   logic [ASSOC-1:0][TAG_W-1:0] row_tag;
   logic [ASSOC-1:0][2:0]       row_perm;

   always_comb begin
      for (int w = 0; w < ASSOC; w++) begin
         row_valid[w] = way_v[cur_set][w];
         row_tag[w]   = way_tag[cur_set][w];
         row_perm[w]  = way_perm[cur_set][w];
      end
   end

   logic [ASSOC-1:0] match_vec;
   logic             present;
   logic             any_free;
   logic [WAY_W-1:0] match_way;
   logic [WAY_W-1:0] free_way;
   logic [WAY_W-1:0] victim_way;

   tagdir_match #(.WAYS(ASSOC), .TAG_W(TAG_W)) i_match (
      .row_valid (row_valid),
      .row_tag   (row_tag),
      .row_perm  (row_perm),
      .key       (cur_tag),
      .match_vec (match_vec),
      .present   (present),
      .match_way (match_way),
      .any_free  (any_free),
      .free_way  (free_way)
   );

   logic             touch_en;
   logic [WAY_W-1:0] touch_way;

   tagdir_lru #(.SETS(SETS), .WAYS(ASSOC)) i_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch_en   (touch_en),
      .touch_set  (cur_set),
      .touch_way  (touch_way),
      .query_set  (cur_set),
      .victim_way (victim_way)
   );

   // command decode
   logic             c_hit, c_err;
   logic [WAY_W-1:0] c_way;
   logic [ADDR_W-1:0] c_addr;
   logic             do_alloc, do_dealloc, do_perm, do_lock;
   logic [CTX_W-1:0] lock_val;
   logic [2:0]       hit_perm;
   logic             read_type;

   assign hit_perm  = way_perm[cur_set][match_way];
   assign read_type = (int'(req_arg) == REQ_LOAD) || (int'(req_arg) == REQ_IFETCH);

   always_comb begin
      c_hit      = 1'b0;
      c_err      = 1'b0;
      c_way      = '0;
      c_addr     = '0;
      do_alloc   = 1'b0;
      do_dealloc = 1'b0;
      do_perm    = 1'b0;
      do_lock    = 1'b0;
      lock_val   = CTX_NONE;
      touch_en   = 1'b0;
      touch_way  = match_way;
      if (req_valid) begin
         case (req_op)
            OP_ACCESS: begin
               if (present) begin
                  c_way    = match_way;
                  touch_en = 1'b1;
                  c_hit    = (hit_perm == PERM_RW) || (hit_perm == PERM_RO && read_type);
               end
            end
            OP_AVAIL: c_hit = present || any_free;
            OP_ALLOC: begin
               if (present || !any_free) c_err = 1'b1;
               else begin
                  c_hit     = 1'b1;
                  c_way     = free_way;
                  do_alloc  = 1'b1;
                  touch_en  = 1'b1;
                  touch_way = free_way;
               end
            end
            OP_DEALLOC: begin
               if (!present) c_err = 1'b1;
               else begin
                  c_hit      = 1'b1;
                  c_way      = match_way;
                  do_dealloc = 1'b1;
               end
            end
            OP_PROBE: begin
               if (present || any_free) c_err = 1'b1;
               else begin
                  c_hit  = 1'b1;
                  c_way  = victim_way;
                  c_addr = {way_tag[cur_set][victim_way], {LINE_BITS{1'b0}}};
               end
            end
            OP_PERM: begin
               if (!present || req_arg > CTX_W'(PERM_STALE)) c_err = 1'b1;
               else begin
                  c_hit   = 1'b1;
                  do_perm = 1'b1;
               end
            end
            OP_LOCK_SET, OP_LOCK_CLR: begin
               if (!present) c_err = 1'b1;
               else begin
                  c_hit    = 1'b1;
                  do_lock  = 1'b1;
                  lock_val = (req_op == OP_LOCK_SET) ? req_arg : CTX_NONE;
               end
            end
            OP_LOCK_TEST: begin
               if (!present) c_err = 1'b1;
               else c_hit = (way_lock[cur_set][match_way] == req_arg);
            end
            default: c_err = 1'b1;
         endcase
      end
   end

   logic [2:0] new_perm;
   logic       perm_drops_lock;

   assign new_perm        = req_arg[2:0];
   assign perm_drops_lock = (new_perm == PERM_INV) || (new_perm == PERM_NP) ||
                            (new_perm == PERM_STALE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < ASSOC; w++) begin
               way_v[s][w]    <= 1'b0;
               way_tag[s][w]  <= '0;
               way_perm[s][w] <= PERM_NP;
               way_lock[s][w] <= CTX_NONE;
            end
      end else begin
         if (do_alloc) begin
            way_v[cur_set][free_way]    <= 1'b1;
            way_tag[cur_set][free_way]  <= cur_tag;
            way_perm[cur_set][free_way] <= PERM_INV;
            way_lock[cur_set][free_way] <= CTX_NONE;
         end
         if (do_dealloc) begin
            way_v[cur_set][match_way]    <= 1'b0;
            way_perm[cur_set][match_way] <= PERM_NP;
            way_lock[cur_set][match_way] <= CTX_NONE;
         end
         if (do_perm) begin
            way_perm[cur_set][match_way] <= new_perm;
            if (perm_drops_lock) way_lock[cur_set][match_way] <= CTX_NONE;
         end
         if (do_lock) way_lock[cur_set][match_way] <= lock_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_way   <= '0;
         rsp_addr  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= c_hit;
         rsp_err   <= c_err;
         rsp_way   <= c_way;
         rsp_addr  <= c_addr;
      end
   end

   // R2
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R2
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R12
   err_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (!rsp_hit && rsp_valid));
   // R7
   unique_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));
   // R9
   probe_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_PROBE && any_free) |=> rsp_err);
endmodule

// File: tb/test_tagdir_top.sv
`timescale 1ns/1ps
module test_tagdir_top;
   localparam int SETS = 4;
   localparam int WAYS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_op = '0;
   logic [15:0] req_addr = '0;
   logic [3:0]  req_arg = '0;
   logic        rsp_valid, rsp_hit, rsp_err;
   logic [1:0]  rsp_way;
   logic [15:0] rsp_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   tagdir_top i_tagdir_top (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_arg(req_arg), .rsp_valid(rsp_valid),
      .rsp_hit(rsp_hit), .rsp_err(rsp_err), .rsp_way(rsp_way), .rsp_addr(rsp_addr)
   );

   // reference model: timestamps give recency
   bit          m_v    [SETS][WAYS];
   logic [9:0]  m_tag  [SETS][WAYS];
   int          m_perm [SETS][WAYS];
   int          m_lock [SETS][WAYS];
   int          m_time [SETS][WAYS];
   int          tick;

   function automatic void model_reset();
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin
            m_v[s][w] = 0; m_tag[s][w] = '0; m_perm[s][w] = 0;
            m_lock[s][w] = 15; m_time[s][w] = WAYS - 1 - w;
         end
      tick = WAYS;
   endfunction

   function automatic void model(input int op, input logic [15:0] a, input int arg,
                                 output bit h, output bit e, output int w,
                                 output logic [15:0] ra);
      int s = int'(a[7:6]);
      logic [9:0] t = a[15:6];
      int pw = -1, fw = -1, vw = 0;
      h = 0; e = 0; w = 0; ra = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (m_v[s][i] && m_tag[s][i] == t && m_perm[s][i] != 0) pw = i;
         if (fw < 0 && (!m_v[s][i] || m_perm[s][i] == 0)) fw = i;
         if (m_time[s][i] < m_time[s][vw]) vw = i;
      end
      case (op)
         0: if (pw >= 0) begin
               w = pw; m_time[s][pw] = tick++;
               h = (m_perm[s][pw] == 3) || (m_perm[s][pw] == 2 && (arg == 0 || arg == 1));
            end
         1: h = (pw >= 0) || (fw >= 0);
         2: if (pw >= 0 || fw < 0) e = 1;
            else begin
               h = 1; w = fw; m_v[s][fw] = 1; m_tag[s][fw] = t; m_perm[s][fw] = 1;
               m_lock[s][fw] = 15; m_time[s][fw] = tick++;
            end
         3: if (pw < 0) e = 1;
            else begin h = 1; w = pw; m_v[s][pw] = 0; m_perm[s][pw] = 0; m_lock[s][pw] = 15; end
         4: if (pw >= 0 || fw >= 0) e = 1;
            else begin h = 1; w = vw; ra = {m_tag[s][vw], 6'b0}; end
         5: if (pw < 0 || arg > 4) e = 1;
            else begin
               h = 1; m_perm[s][pw] = arg;
               if (arg == 0 || arg == 1 || arg == 4) m_lock[s][pw] = 15;
            end
         6, 7: if (pw < 0) e = 1;
            else begin h = 1; m_lock[s][pw] = (op == 6) ? arg : 15; end
         8: if (pw < 0) e = 1; else h = (m_lock[s][pw] == arg);
         default: e = 1;
      endcase
   endfunction

   function automatic string op_req(input int op);
      case (op)
         0: return "R4";  1: return "R6";  2: return "R7";  3: return "R8";
         4: return "R9";  5: return "R10"; 6, 7, 8: return "R11";
         default: return "R12";
      endcase
   endfunction

   // drive at a falling edge, compare at the next falling edge
   task automatic do_cmd(input int op, input logic [15:0] a, input int arg, input string req);
      bit h, e; int w; logic [15:0] ra;
      req_valid = 1'b1; req_op = 4'(op); req_addr = a; req_arg = 4'(arg);
      model(op, a, arg, h, e, w, ra);
      @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b1 || rsp_hit !== h || rsp_err !== e ||
          rsp_way !== 2'(w) || rsp_addr !== ra) begin
         fails++;
         $display("FAIL %s op=%0d addr=%h arg=%0d: got v=%b hit=%b err=%b way=%0d addr=%h, expected v=1 hit=%b err=%b way=%0d addr=%h",
                  req, op, a, arg, rsp_valid, rsp_hit, rsp_err, rsp_way, rsp_addr, h, e, w, ra);
      end
   endtask

   task automatic check_idle(input string req);
      req_valid = 1'b0;
      @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0) begin
         fails++;
         $display("FAIL %s idle: got rsp_valid=%b expected 0", req, rsp_valid);
      end
   endtask

   function automatic logic [15:0] mk(input int hi, input int set, input int off);
      return {3'(hi), 5'd0, 2'(set), 6'(off)};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R3 reset state
      checks++;
      if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_err !== 1'b0) begin
         fails++;
         $display("FAIL R3 reset: got v=%b h=%b e=%b expected 0 0 0", rsp_valid, rsp_hit, rsp_err);
      end
      do_cmd(1, mk(1, 1, 0), 0, "R3");
      do_cmd(4, mk(1, 1, 0), 0, "R12");
      // R1 offset ignored, index at bits 7:6
      for (int i = 0; i < WAYS; i++) do_cmd(2, mk(i, 1, 5 * i), 0, "R7");
      do_cmd(0, mk(0, 1, 63), 0, "R1");
      do_cmd(1, mk(5, 1, 0), 0, "R6");
      do_cmd(1, mk(5, 2, 0), 0, "R1");
      do_cmd(4, mk(5, 1, 0), 0, "R9");
      do_cmd(2, mk(5, 1, 0), 0, "R12");
      do_cmd(2, mk(1, 1, 0), 0, "R12");
      do_cmd(5, mk(0, 1, 0), 2, "R10");
      do_cmd(0, mk(0, 1, 0), 2, "R4");
      do_cmd(0, mk(0, 1, 0), 1, "R4");
      do_cmd(4, mk(5, 1, 0), 0, "R5");
      do_cmd(0, mk(1, 1, 0), 0, "R4");
      do_cmd(5, mk(1, 1, 0), 3, "R10");
      do_cmd(0, mk(1, 1, 0), 2, "R4");
      do_cmd(6, mk(2, 1, 0), 5, "R11");
      do_cmd(8, mk(2, 1, 0), 5, "R11");
      do_cmd(8, mk(2, 1, 0), 3, "R11");
      do_cmd(5, mk(2, 1, 0), 2, "R10");
      do_cmd(8, mk(2, 1, 0), 5, "R10");
      do_cmd(5, mk(2, 1, 0), 4, "R10");
      do_cmd(8, mk(2, 1, 0), 5, "R10");
      do_cmd(0, mk(2, 1, 0), 0, "R4");
      do_cmd(5, mk(2, 1, 0), 7, "R12");
      do_cmd(6, mk(3, 1, 0), 9, "R11");
      do_cmd(3, mk(3, 1, 0), 0, "R8");
      do_cmd(8, mk(3, 1, 0), 9, "R12");
      do_cmd(1, mk(6, 1, 0), 0, "R6");
      do_cmd(2, mk(6, 1, 0), 0, "R7");
      do_cmd(8, mk(6, 1, 0), 15, "R7");
      do_cmd(5, mk(6, 1, 0), 0, "R10");
      do_cmd(2, mk(7, 1, 0), 0, "R7");
      do_cmd(15, mk(7, 1, 0), 0, "R12");
      do_cmd(7, mk(7, 1, 0), 0, "R11");
      check_idle("R2");
      // constrained random traffic
      for (int n = 0; n < 3000; n++) begin
         int op = int'($urandom_range(0, 9));
         int arg;
         if (op == 9) op = 12;
         arg = (op == 5) ? int'($urandom_range(0, 5)) :
               (op == 0) ? int'($urandom_range(0, 2)) : int'($urandom_range(0, 15));
         do_cmd(op, mk(int'($urandom_range(0, 5)), int'($urandom_range(0, 3)),
                       int'($urandom_range(0, 63))), arg, op_req(op));
      end
      check_idle("R2");
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule